// File: doc/BRIEF.md
# Bus-Master Disk DMA Register Engine

This block is one channel of a bus-master disk DMA controller. Software sees a small byte-wide register window: a command register that starts and stops the engine and picks the direction, a status register with activity, error and interrupt flags plus two per-drive capability flags, and a 32-bit pointer to a descriptor table in memory. Once started, the engine reads descriptors through a 32-bit memory read port and then issues one device handshake per byte. Each handshake carries the next buffer byte address and the direction.

Each descriptor is two words. The first word holds the buffer start address. The second word holds a byte count in bits 15:0, where 0 stands for 65536, and an end-of-table flag in bit 31. The engine walks the table in steps of 8 bytes. It stops after the flagged entry, clears the activity flag and raises the interrupt flag. A memory error response, or the device ending early, raises the error flag instead. A verdict byte is also provided, which gives the completion judgement a driver would otherwise compute from the status register.

The sequencer has four states. IDLE leaves on a start write and goes to GET_ADDR. GET_ADDR reads the buffer address and moves to GET_CNT on acknowledge. GET_CNT reads the count and flag and moves to MOVE. MOVE issues the byte handshakes. From MOVE, the last byte of a non-final entry returns to GET_ADDR, and the last byte of the final entry returns to IDLE with interrupt. A memory error or a device end goes to IDLE with error. A stop write returns any state to IDLE with neither flag.

Top module: `bmd_engine`

## Requirements
- R1: After reset every register offset 0..7 reads 0x00, `irq` is 0, and neither `mem_req` nor `dev_req` is asserted.
- R2: Offset 0 reads back command bits 0 (run) and 3 (direction). Offsets 4..7 hold the table pointer little-endian, with offset 4 = bits 7:0. Offsets 1 and 3 read 0x00 and ignore writes.
- R3: A write to offset 0 with bit 0 = 1 while the run bit is 0 sets status bit 0 (active) and starts fetching. The entry's buffer address is read at pointer+0, and the word at pointer+4 carries bit 31 = end flag and bits 15:0 = byte count. A write of bit 0 = 1 while run is already 1 starts nothing.
- R4: Each entry produces one `dev_req`/`dev_ack` handshake per byte, at consecutive addresses from the entry's buffer address. `dev_to_mem` equals command bit 3, where 1 means device-to-memory.
- R5: A count field of 0 moves 65536 bytes.
- R6: After a non-final entry the next entry is read 8 bytes further on. After the last byte of the flagged entry, status[2:0] becomes 3'b100 (active clear, error clear, interrupt set).
- R7: Writing 0 to command bit 0 while active ends the transfer. Active clears, neither error nor interrupt is set, and no further memory or device requests follow.
- R8: A `mem_err` on a descriptor read sets status bit 1 (error) and clears active.
- R9: `dev_done` while active, unless it coincides with the acknowledge of the final byte, sets error and clears active.
- R10: Writing 1 to status bit 1 or bit 2 clears that bit; writing 0 leaves it unchanged.
- R11: Status bits 5 and 6 are capability flags for drive 0 and drive 1. They are read/write, independent of each other, and change only on a status write.
- R12: When the engine sets the interrupt in the same cycle as a write clearing it, the interrupt stays set.
- R13: `verdict` is 0x00 when status[2:0] = 3'b100, and otherwise the status byte with bit 4 set.
- R14: `irq` equals status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word address |
| mem_ack | input | 1 | Read completed, `mem_rdata` valid |
| mem_err | input | 1 | Read failed (error response) |
| mem_rdata | input | 32 | Descriptor word |
| dev_req | output | 1 | Byte handshake request |
| dev_addr | output | 32 | Memory byte address of current byte |
| dev_to_mem | output | 1 | 1 = device-to-memory direction |
| dev_ack | input | 1 | Byte moved |
| dev_done | input | 1 | Device has ended the transfer |
| irq | output | 1 | Interrupt flag |
| verdict | output | 8 | Completion judgement byte |

## Verification
The engine raising the interrupt flag on the final byte and a host write that clears the same flag can land on one clock edge. The bench holds the device acknowledge back until the last byte is requested, leaves the interrupt still set from the previous run, and then drives the acknowledge and the status write in the same cycle. The result is judged by reading back interrupt set and status[2:0] = 3'b100. A second overlap is the device ending together with the final byte acknowledge, where the acknowledge has priority. The sequencer and register assertions cover that overlap.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

    localparam logic [2:0] OFF_CMD  = 3'd0;
    localparam logic [2:0] OFF_STAT = 3'd2;

    localparam int CMD_RUN  = 0;
    localparam int CMD_DIR  = 3;
    localparam int STS_ACT  = 0;
    localparam int STS_ERR  = 1;
    localparam int STS_IRQ  = 2;
    localparam int STS_CAP0 = 5;
    localparam int STS_CAP1 = 6;

    typedef enum logic [1:0] {
        SQ_IDLE     = 2'd0,
        SQ_GET_ADDR = 2'd1,
        SQ_GET_CNT  = 2'd2,
        SQ_MOVE     = 2'd3
    } seq_state_e;

endpackage

// File: rtl/bmd_regs.sv
module bmd_regs
    import bmd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          active,
    input  logic          set_irq,
    input  logic          set_err,
    output logic          start,
    output logic          stop,
    output logic          dir,
    output logic [AW-1:0] tbl_ptr,
    output logic [7:0]    status
);

    localparam int NB = AW / 8;

    logic          run_q;
    logic          dir_q;
    logic          err_q;
    logic          irq_q;
    logic [1:0]    cap_q;
    logic [AW-1:0] ptr_q;

    logic wr_cmd;
    logic wr_sts;

    assign wr_cmd = reg_we && (reg_addr == OFF_CMD);
    assign wr_sts = reg_we && (reg_addr == OFF_STAT);

    assign start = wr_cmd &&  reg_wdata[CMD_RUN] && !run_q;
    assign stop  = wr_cmd && !reg_wdata[CMD_RUN] &&  run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            dir_q <= 1'b0;
        end else if (wr_cmd) begin
            run_q <= reg_wdata[CMD_RUN];
            dir_q <= reg_wdata[CMD_DIR];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            irq_q <= 1'b0;
            cap_q <= 2'b00;
        end else begin
            err_q <= set_err | (err_q & ~(wr_sts & reg_wdata[STS_ERR]));
            irq_q <= set_irq | (irq_q & ~(wr_sts & reg_wdata[STS_IRQ]));
            if (wr_sts) begin
                cap_q <= {reg_wdata[STS_CAP1], reg_wdata[STS_CAP0]};
            end
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_ptr_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr_q[b*8 +: 8] <= 8'h00;
            end else if (reg_we && (reg_addr == 3'(4 + b))) begin
                ptr_q[b*8 +: 8] <= reg_wdata;
            end
        end
    end

    assign status  = {1'b0, cap_q[1], cap_q[0], 2'b00, irq_q, err_q, active};
    assign dir     = dir_q;
    assign tbl_ptr = ptr_q;

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == OFF_CMD) begin
            reg_rdata[CMD_RUN] = run_q;
            reg_rdata[CMD_DIR] = dir_q;
        end else if (reg_addr == OFF_STAT) begin
            reg_rdata = status;
        end else if (reg_addr[2]) begin
            reg_rdata = ptr_q[reg_addr[1:0]*8 +: 8];
        end
    end

    // R10
    irq_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && reg_wdata[STS_IRQ] && !set_irq) |=> !irq_q);

    // R12
    irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_irq |=> irq_q);

    // R11
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sts |=> $stable(cap_q));

    // R8
    err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_err |=> err_q);

endmodule

// File: rtl/bmd_seq.sv
module bmd_seq
    import bmd_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    input  logic          dir,
    input  logic [AW-1:0] tbl_ptr,
    output logic          active,
    output logic          set_irq,
    output logic          set_err,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic [31:0]   mem_rdata,
    output logic          dev_req,
    output logic [AW-1:0] dev_addr,
    output logic          dev_to_mem,
    input  logic          dev_ack,
    input  logic          dev_done
);

    localparam int REM_W = CNT_W + 1;
    localparam int EOT_BIT = 31;
    localparam logic [AW-1:0] ENTRY_BYTES = AW'(8);
    localparam logic [AW-1:0] CNT_WORD    = AW'(4);

    seq_state_e    st, st_nx;
    logic [AW-1:0] off_q;
    logic [AW-1:0] buf_q;
    logic [REM_W-1:0] rem_q;
    logic          eot_q;

    logic last_byte;
    logic load_addr, load_cnt, step, next_entry, clr_off;

    assign last_byte = (rem_q == REM_W'(1));

    always_comb begin
        st_nx      = st;
        set_irq    = 1'b0;
        set_err    = 1'b0;
        load_addr  = 1'b0;
        load_cnt   = 1'b0;
        step       = 1'b0;
        next_entry = 1'b0;
        clr_off    = 1'b0;
        if (stop) begin
            st_nx = SQ_IDLE;
        end else begin
            unique case (st)
                SQ_IDLE: begin
                    if (start) begin
                        st_nx   = SQ_GET_ADDR;
                        clr_off = 1'b1;
                    end
                end
                SQ_GET_ADDR: begin
                    if (mem_err || dev_done) begin
                        st_nx   = SQ_IDLE;
                        set_err = 1'b1;
                    end else if (mem_ack) begin
                        st_nx     = SQ_GET_CNT;
                        load_addr = 1'b1;
                    end
                end
                SQ_GET_CNT: begin
                    if (mem_err || dev_done) begin
                        st_nx   = SQ_IDLE;
                        set_err = 1'b1;
                    end else if (mem_ack) begin
                        st_nx    = SQ_MOVE;
                        load_cnt = 1'b1;
                    end
                end
                SQ_MOVE: begin
                    if (dev_ack && last_byte && eot_q) begin
                        st_nx   = SQ_IDLE;
                        set_irq = 1'b1;
                    end else if (dev_done) begin
                        st_nx   = SQ_IDLE;
                        set_err = 1'b1;
                    end else if (dev_ack) begin
                        step = 1'b1;
                        if (last_byte) begin
                            st_nx      = SQ_GET_ADDR;
                            next_entry = 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= SQ_IDLE;
            off_q <= '0;
            buf_q <= '0;
            rem_q <= '0;
            eot_q <= 1'b0;
        end else begin
            st <= st_nx;
            if (clr_off) begin
                off_q <= '0;
            end else if (next_entry) begin
                off_q <= off_q + ENTRY_BYTES;
            end
            if (load_addr) begin
                buf_q <= mem_rdata[AW-1:0];
            end else if (step) begin
                buf_q <= buf_q + AW'(1);
            end
            if (load_cnt) begin
                rem_q <= (mem_rdata[CNT_W-1:0] == '0) ? (REM_W'(1) << CNT_W)
                                                      : REM_W'(mem_rdata[CNT_W-1:0]);
                eot_q <= mem_rdata[EOT_BIT];
            end else if (step) begin
                rem_q <= rem_q - REM_W'(1);
            end
        end
    end

    always_comb begin
        active     = (st != SQ_IDLE);
        mem_req    = (st == SQ_GET_ADDR) || (st == SQ_GET_CNT);
        mem_addr   = tbl_ptr + off_q + ((st == SQ_GET_CNT) ? CNT_WORD : '0);
        dev_req    = (st == SQ_MOVE);
        dev_addr   = buf_q;
        dev_to_mem = dir;
    end

    // R6
    final_byte_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_MOVE && dev_ack && last_byte && eot_q && !stop) |=> (st == SQ_IDLE));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_MOVE && dev_ack && !last_byte && !dev_done && !stop)
        |=> (dev_addr == $past(dev_addr) + AW'(1)));

    // R8
    mem_err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_err && !stop) |=> !active);

    // R5
    rem_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_MOVE) |-> (rem_q != '0));

    // R7
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!mem_req && !dev_req));

endmodule

// File: rtl/bmd_verdict.sv
module bmd_verdict (
    input  logic [7:0] status,
    output logic [7:0] verdict
);

    localparam logic [2:0] GOOD_END = 3'b100;
    localparam logic [7:0] BAD_MARK = 8'h10;

    always_comb begin
        if (status[2:0] == GOOD_END) begin
            verdict = 8'h00;
        end else begin
            verdict = status | BAD_MARK;
        end
    end

endmodule

// File: rtl/bmd_engine.sv
module bmd_engine
    import bmd_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic [31:0]   mem_rdata,
    output logic          dev_req,
    output logic [AW-1:0] dev_addr,
    output logic          dev_to_mem,
    input  logic          dev_ack,
    input  logic          dev_done,
    output logic          irq,
    output logic [7:0]    verdict
);

    logic          start, stop, dir, active, set_irq, set_err;
    logic [AW-1:0] tbl_ptr;
    logic [7:0]    status;

    bmd_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .active    (active),
        .set_irq   (set_irq),
        .set_err   (set_err),
        .start     (start),
        .stop      (stop),
        .dir       (dir),
        .tbl_ptr   (tbl_ptr),
        .status    (status)
    );

    bmd_seq #(.AW(AW), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .stop       (stop),
        .dir        (dir),
        .tbl_ptr    (tbl_ptr),
        .active     (active),
        .set_irq    (set_irq),
        .set_err    (set_err),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_err    (mem_err),
        .mem_rdata  (mem_rdata),
        .dev_req    (dev_req),
        .dev_addr   (dev_addr),
        .dev_to_mem (dev_to_mem),
        .dev_ack    (dev_ack),
        .dev_done   (dev_done)
    );

    bmd_verdict u_verdict (
        .status  (status),
        .verdict (verdict)
    );

    assign irq = status[STS_IRQ];

    // R14
    irq_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == reg_rdata[STS_IRQ] || reg_addr != OFF_STAT);

endmodule

// File: tb/tb_bmd_engine.sv
module tb_bmd_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        mem_req, mem_ack, mem_err;
    logic [31:0] mem_addr, mem_rdata;
    logic        dev_req, dev_ack, dev_done, dev_to_mem;
    logic [31:0] dev_addr;
    logic        irq;
    logic [7:0]  verdict;

    logic [31:0] tbl [16];
    logic        ack_en = 1'b0;
    logic        done_en = 1'b0;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = 32'h0;
    logic        log_clr = 1'b0;
    int          nlog = 0;
    logic [31:0] log_a [64];
    logic [31:0] last_a = 32'h0;
    logic        seen_dir = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    assign mem_ack   = mem_req;
    assign mem_rdata = tbl[mem_addr[5:2]];
    assign mem_err   = mem_req && err_en && (mem_addr == err_addr);
    assign dev_ack   = dev_req && ack_en;
    assign dev_done  = done_en;

    bmd_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .dev_req(dev_req), .dev_addr(dev_addr),
        .dev_to_mem(dev_to_mem), .dev_ack(dev_ack), .dev_done(dev_done),
        .irq(irq), .verdict(verdict)
    );

    always @(posedge clk) begin
        if (log_clr) begin
            nlog <= 0;
        end else if (dev_req && dev_ack) begin
            if (nlog < 64) log_a[nlog] <= dev_addr;
            last_a   <= dev_addr;
            seen_dir <= dev_to_mem;
            nlog     <= nlog + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic launch(input logic [31:0] ptr, input logic to_mem);
        wr(3'd4, ptr[7:0]);  wr(3'd5, ptr[15:8]);
        wr(3'd6, ptr[23:16]); wr(3'd7, ptr[31:24]);
        wr(3'd0, 8'h00);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        wr(3'd0, to_mem ? 8'h09 : 8'h01);
    endtask

    task automatic wait_idle(input int max);
        logic [7:0] s;
        for (int i = 0; i < max; i++) begin
            rd(3'd2, s);
            if (!s[0]) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_dev_req();
        for (int i = 0; i < 50; i++) begin
            if (dev_req) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1", "reset register", {24'h0, d}, 32'h0);
        end
        chk("R1", "reset irq", {31'h0, irq}, 32'h0);
        chk("R1", "reset requests", {30'h0, mem_req, dev_req}, 32'h0);
        chk("R13", "verdict idle", {24'h0, verdict}, 32'h10);
    endtask

    task automatic t_regmap();
        logic [7:0] d;
        wr(3'd4, 8'h78); wr(3'd5, 8'h56); wr(3'd6, 8'h34); wr(3'd7, 8'h12);
        rd(3'd4, d); chk("R2", "ptr byte 4", {24'h0, d}, 32'h78);
        rd(3'd7, d); chk("R2", "ptr byte 7", {24'h0, d}, 32'h12);
        wr(3'd1, 8'hFF); wr(3'd3, 8'hFF);
        rd(3'd1, d); chk("R2", "offset 1", {24'h0, d}, 32'h0);
        rd(3'd3, d); chk("R2", "offset 3", {24'h0, d}, 32'h0);
        wr(3'd0, 8'h08);
        rd(3'd0, d); chk("R2", "command readback", {24'h0, d}, 32'h08);
        rd(3'd2, d); chk("R3", "no start without run", {24'h0, d}, 32'h0);
    endtask

    task automatic t_single();
        logic [7:0] d;
        tbl[0] = 32'h0000_2000;
        tbl[1] = 32'h8000_0005;
        ack_en = 1'b1;
        launch(32'h0000_1000, 1'b1);
        rd(3'd2, d); chk("R3", "active after start", {31'h0, d[0]}, 32'h1);
        wait_idle(100);
        chk("R4", "byte count", nlog, 5);
        for (int i = 0; i < 5; i++)
            chk("R4", "byte address", log_a[i], 32'h2000 + i);
        chk("R4", "direction to memory", {31'h0, seen_dir}, 32'h1);
        rd(3'd2, d); chk("R6", "good end status", {29'h0, d[2:0]}, 32'h4);
        chk("R14", "irq output", {31'h0, irq}, 32'h1);
        chk("R13", "verdict good", {24'h0, verdict}, 32'h0);
        wr(3'd0, 8'h09);
        repeat (4) @(negedge clk);
        chk("R3", "no restart while run set", nlog, 5);
        rd(3'd2, d); chk("R3", "still idle", {31'h0, d[0]}, 32'h0);
    endtask

    task automatic t_w1c();
        logic [7:0] d;
        wr(3'd2, 8'h00);
        rd(3'd2, d); chk("R10", "zero write keeps irq", {31'h0, d[2]}, 32'h1);
        wr(3'd2, 8'h04);
        rd(3'd2, d); chk("R10", "one write clears irq", {31'h0, d[2]}, 32'h0);
        chk("R14", "irq output low", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_chain();
        logic [7:0] d;
        tbl[4] = 32'h0000_3000; tbl[5] = 32'h0000_0002;
        tbl[6] = 32'h0000_5000; tbl[7] = 32'h8000_0003;
        launch(32'h0000_1010, 1'b0);
        wait_idle(100);
        chk("R6", "chained byte count", nlog, 5);
        chk("R6", "first entry addr", log_a[1], 32'h3001);
        chk("R6", "second entry start", log_a[2], 32'h5000);
        chk("R6", "second entry end", log_a[4], 32'h5002);
        chk("R4", "direction from memory", {31'h0, seen_dir}, 32'h0);
        rd(3'd2, d); chk("R6", "chain end status", {29'h0, d[2:0]}, 32'h4);
        wr(3'd2, 8'h06);
    endtask

    task automatic t_caps();
        logic [7:0] d;
        wr(3'd2, 8'h20);
        rd(3'd2, d); chk("R11", "drive0 flag", {30'h0, d[6:5]}, 32'h1);
        wr(3'd2, 8'h40);
        rd(3'd2, d); chk("R11", "drive1 flag", {30'h0, d[6:5]}, 32'h2);
        wr(3'd0, 8'h00);
        rd(3'd2, d); chk("R11", "flags kept", {30'h0, d[6:5]}, 32'h2);
        wr(3'd2, 8'h00);
        rd(3'd2, d); chk("R11", "flags cleared", {24'h0, d}, 32'h0);
    endtask

    task automatic t_stop();
        logic [7:0] d;
        tbl[0] = 32'h0000_4000;
        tbl[1] = 32'h8000_0008;
        ack_en = 1'b0;
        launch(32'h0000_1000, 1'b0);
        wait_dev_req();
        wr(3'd0, 8'h00);
        rd(3'd2, d); chk("R7", "stop status", {24'h0, d}, 32'h0);
        chk("R7", "stop requests", {30'h0, mem_req, dev_req}, 32'h0);
        repeat (3) @(negedge clk);
        chk("R7", "no bytes after stop", nlog, 0);
    endtask

    task automatic t_memerr();
        logic [7:0] d;
        tbl[4] = 32'h0000_6000; tbl[5] = 32'h0000_0002;
        err_en = 1'b1; err_addr = 32'h0000_1018;
        ack_en = 1'b1;
        launch(32'h0000_1010, 1'b0);
        wait_idle(100);
        err_en = 1'b0;
        chk("R8", "bytes before error", nlog, 2);
        rd(3'd2, d); chk("R8", "error status", {24'h0, d}, 32'h02);
        chk("R13", "verdict error", {24'h0, verdict}, 32'h12);
        wr(3'd2, 8'h02);
        rd(3'd2, d); chk("R10", "error cleared", {24'h0, d}, 32'h0);
    endtask

    task automatic t_devend();
        logic [7:0] d;
        tbl[0] = 32'h0000_7000;
        tbl[1] = 32'h8000_0004;
        ack_en = 1'b0;
        launch(32'h0000_1000, 1'b1);
        wait_dev_req();
        done_en = 1'b1;
        @(negedge clk);
        done_en = 1'b0;
        rd(3'd2, d); chk("R9", "early end status", {24'h0, d}, 32'h02);
        chk("R9", "no request after end", {31'h0, dev_req}, 32'h0);
        wr(3'd2, 8'h06);
    endtask

    task automatic t_big();
        logic [7:0] d;
        tbl[0] = 32'h0001_0000;
        tbl[1] = 32'h8000_0000;
        ack_en = 1'b1;
        launch(32'h0000_1000, 1'b1);
        wait_idle(70000);
        chk("R5", "zero count length", nlog, 65536);
        chk("R5", "last address", last_a, 32'h0001_FFFF);
        rd(3'd2, d); chk("R5", "big end status", {29'h0, d[2:0]}, 32'h4);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        tbl[0] = 32'h0000_8000;
        tbl[1] = 32'h8000_0001;
        ack_en = 1'b0;
        launch(32'h0000_1000, 1'b0);
        wait_dev_req();
        ack_en = 1'b1;
        reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h04;
        @(negedge clk);
        reg_we = 1'b0; ack_en = 1'b0;
        chk("R12", "irq kept on collision", {31'h0, irq}, 32'h1);
        rd(3'd2, d); chk("R12", "status on collision", {29'h0, d[2:0]}, 32'h4);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) tbl[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_single();
        t_w1c();
        t_chain();
        t_caps();
        t_stop();
        t_memerr();
        t_devend();
        t_big();
        t_collide();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule